// File: doc/BRIEF.md
# Receive-Scaling Configuration Port

This block is the software-facing front end of a receive-scaling engine. The engine's secret hash key and its queue lookup table are not mapped directly into the register space. Software reaches them through three registers: a control register, a data register and a command register. The command register carries an entry index, a store selector, a read/write flag and a self-clearing busy flag.

To write an entry, software first places a word in the data register. It then writes the command register with the index, the store and busy set. The block commits the word a fixed number of cycles later and drops busy. A read command runs the same way: it copies the addressed entry into the data register before busy drops. The hash key is ten 32-bit words. The lookup table has 256 entries, and each entry holds a 4-bit receive channel number. The four control bits drive the engine's enable inputs directly.

Registers are selected by a 2-bit select code: 0 = control, 1 = command, 2 = data. Reads are registered, so the value appears one clock after the select is presented.

Top module: `rss_cfg_port`

## Requirements
- R1: After reset, the control, command and data registers all read 0, busy is 0, and the four enable outputs are 0.
- R2: A write to the control register (select 0) stores bits 3:0. Bit 0 drives hash_en, bit 1 drives ipv4_hash_en, bit 2 drives tcp4_hash_en and bit 3 drives udp4_hash_en. The register reads back with bits 31:4 equal to 0.
- R3: A command-register write (select 1) with bit 0 equal to 0 only stores the fields and starts nothing. The fields are: bit 0 busy, bit 1 command (0 = write, 1 = read), bit 2 store (0 = lookup table, 1 = hash key), and bits 15:8 index. The data register and both stores stay unchanged, and the register reads back the stored fields.
- R4: A command-register write with bit 0 equal to 1 sets busy. Busy reads back as 1 for exactly 2 cycles and then clears by itself. The index, store and command fields remain readable afterwards.
- R5: A write command to the hash key at index 0 to 9 stores the full 32-bit data word in that key word.
- R6: A write command to the lookup table at index 0 to 255 stores data bits 3:0 as that entry's channel number. A read of the entry returns it zero-extended to 32 bits.
- R7: A command that addresses the hash key with an index above 9 changes no key word and still clears busy. As a read, it loads 0 into the data register.
- R8: While busy is set, writes to the data register and to the command register are ignored.
- R9: A read command places the addressed entry in the data register, where it is visible once busy has cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes (0 control, 1 command, 2 data) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Registered read data, one cycle after rd_sel |
| hash_en | output | 1 | Global hashing enable |
| ipv4_hash_en | output | 1 | IPv4 header hashing enable |
| tcp4_hash_en | output | 1 | TCP-over-IPv4 hashing enable |
| udp4_hash_en | output | 1 | UDP-over-IPv4 hashing enable |

## Verification
Every key word and every lookup-table entry is first written with an index-derived pattern and then read back through read commands. The table patterns carry junk in their upper bits, which shows that only the channel field is kept and that no entry aliases another. Busy is sampled cycle by cycle after a command starts, to pin down the 2-cycle window. Writes are issued into that window, to show that they are dropped and that neither the committed word nor a second index is disturbed. Key indices past the last word, and command writes with busy clear, are checked against the rest of the key store to show that they change nothing.

// File: rtl/rss_cfg_pkg.sv
package rss_cfg_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned CTRL_W  = 4;
  localparam int unsigned CMD_BUSY_BIT = 0;
  localparam int unsigned CMD_RD_BIT   = 1;
  localparam int unsigned CMD_KEY_BIT  = 2;
  localparam int unsigned CMD_IDX_LO   = 8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/rss_store_ram.sv
module rss_store_ram #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rss_cmd_seq.sv
module rss_cmd_seq #(
  parameter int unsigned COMMIT_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = (COMMIT_CYCLES > 1) ? $clog2(COMMIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(COMMIT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy) begin
      if (cnt_q == LAST) busy <= 1'b0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = busy && (cnt_q == LAST);

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_q != LAST) |=> busy);
  // R4
  busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_q == LAST) |=> !busy);
endmodule

// File: rtl/rss_cfg_port.sv
module rss_cfg_port
  import rss_cfg_pkg::*;
#(
  parameter int unsigned KEY_WORDS     = 10,
  parameter int unsigned TBL_DEPTH     = 256,
  parameter int unsigned CHAN_W        = 4,
  parameter int unsigned COMMIT_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [1:0]        rd_sel,
  output logic [REG_W-1:0]  rd_data,
  output logic              hash_en,
  output logic              ipv4_hash_en,
  output logic              tcp4_hash_en,
  output logic              udp4_hash_en
);
  localparam int unsigned KAW = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;
  localparam int unsigned TAW = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [IDX_W-1:0]  idx_q;
  logic              key_sel_q;
  logic              rd_cmd_q;
  logic [REG_W-1:0]  data_q;
  logic              busy, done;

  logic cmd_wr, data_wr, ctrl_wr, start;
  logic key_hit, tbl_hit;
  logic [REG_W-1:0]  key_rdata;
  logic [CHAN_W-1:0] tbl_rdata;

  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
  assign cmd_wr  = wr_en && (wr_sel == SEL_CMD)  && !busy;
  assign data_wr = wr_en && (wr_sel == SEL_DATA) && !busy;
  assign start   = cmd_wr && wr_data[CMD_BUSY_BIT];

  assign key_hit = key_sel_q  && (32'(idx_q) < 32'(KEY_WORDS));
  assign tbl_hit = !key_sel_q && (32'(idx_q) < 32'(TBL_DEPTH));

  rss_cmd_seq #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done)
  );

  rss_store_ram #(.WIDTH(REG_W), .DEPTH(KEY_WORDS)) u_key (
    .clk(clk),
    .we(done && !rd_cmd_q && key_hit),
    .waddr(idx_q[KAW-1:0]),
    .wdata(data_q),
    .raddr(idx_q[KAW-1:0]),
    .rdata(key_rdata)
  );

  rss_store_ram #(.WIDTH(CHAN_W), .DEPTH(TBL_DEPTH)) u_tbl (
    .clk(clk),
    .we(done && !rd_cmd_q && tbl_hit),
    .waddr(idx_q[TAW-1:0]),
    .wdata(data_q[CHAN_W-1:0]),
    .raddr(idx_q[TAW-1:0]),
    .rdata(tbl_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      idx_q     <= '0;
      key_sel_q <= 1'b0;
      rd_cmd_q  <= 1'b0;
      data_q    <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wr_data[CTRL_W-1:0];
      if (cmd_wr) begin
        idx_q     <= wr_data[CMD_IDX_LO +: IDX_W];
        key_sel_q <= wr_data[CMD_KEY_BIT];
        rd_cmd_q  <= wr_data[CMD_RD_BIT];
      end
      if (done && rd_cmd_q) begin
        if (key_hit)      data_q <= key_rdata;
        else if (tbl_hit) data_q <= {{(REG_W-CHAN_W){1'b0}}, tbl_rdata};
        else              data_q <= '0;
      end else if (data_wr) begin
        data_q <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_sel)
        SEL_CTRL: rd_data <= {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
        SEL_CMD:  rd_data <= {{(REG_W-CMD_IDX_LO-IDX_W){1'b0}}, idx_q,
                              {(CMD_IDX_LO-3){1'b0}}, key_sel_q, rd_cmd_q, busy};
        SEL_DATA: rd_data <= data_q;
        default:  rd_data <= '0;
      endcase
    end
  end

  assign hash_en      = ctrl_q[0];
  assign ipv4_hash_en = ctrl_q[1];
  assign tcp4_hash_en = ctrl_q[2];
  assign udp4_hash_en = ctrl_q[3];

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!busy && ctrl_q == '0 && data_q == '0));
  // R2
  ctrl_out_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_CTRL) |=>
      (hash_en == $past(wr_data[0]) && udp4_hash_en == $past(wr_data[3])));
  // R3
  no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_CMD && !wr_data[0] && !busy) |=> !busy);
  // R8
  data_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(data_q)));
  // R8
  cmd_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(idx_q) && $stable(key_sel_q) && $stable(rd_cmd_q)));
endmodule

// File: tb/rss_cfg_port_test.sv
module rss_cfg_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        hash_en, ipv4_hash_en, tcp4_hash_en, udp4_hash_en;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] kexp [10];

  always #2 clk = ~clk;

  rss_cfg_port uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .hash_en(hash_en),
    .ipv4_hash_en(ipv4_hash_en), .tcp4_hash_en(tcp4_hash_en),
    .udp4_hash_en(udp4_hash_en)
  );

  function automatic logic [31:0] cmdw(input logic key, input logic rd,
                                       input logic [7:0] idx, input logic go);
    return {16'd0, idx, 5'd0, key, rd, go};
  endfunction

  function automatic logic [31:0] kpat(input int i);
    return (32'h9E3779B9 * (i + 1)) ^ 32'h00A5_5A00;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] val);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [31:0] val);
    rd_sel = sel;
    @(posedge clk); #1;
    val = rd_data;
    @(negedge clk);
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    int tries = 0;
    do begin
      reg_read(2'd1, v);
      tries++;
    end while (v[0] && tries < 50);
    if (v[0]) check({tag, " busy stuck"}, v & 32'h1, 32'h0);
  endtask

  task automatic do_write(input logic key, input logic [7:0] idx, input logic [31:0] val);
    reg_write(2'd2, val);
    reg_write(2'd1, cmdw(key, 1'b0, idx, 1'b1));
    wait_idle("write");
  endtask

  task automatic do_read(input logic key, input logic [7:0] idx, output logic [31:0] val);
    reg_write(2'd1, cmdw(key, 1'b1, idx, 1'b1));
    wait_idle("read");
    reg_read(2'd2, val);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    reg_read(2'd0, v); check("R1 ctrl", v, 32'h0);
    reg_read(2'd1, v); check("R1 cmd", v, 32'h0);
    reg_read(2'd2, v); check("R1 data", v, 32'h0);
    check("R1 outputs", {28'd0, udp4_hash_en, tcp4_hash_en, ipv4_hash_en, hash_en}, 32'h0);

    // R2 control bits
    reg_write(2'd0, 32'hFFFF_FFF5);
    reg_read(2'd0, v); check("R2 ctrl readback", v, 32'h5);
    check("R2 outputs 5", {28'd0, udp4_hash_en, tcp4_hash_en, ipv4_hash_en, hash_en}, 32'h5);
    reg_write(2'd0, 32'h0000_000A);
    check("R2 outputs A", {28'd0, udp4_hash_en, tcp4_hash_en, ipv4_hash_en, hash_en}, 32'hA);

    // R5 key sweep, R9 read back
    for (int i = 0; i < 10; i++) begin
      do_write(1'b1, 8'(i), kpat(i));
      kexp[i] = kpat(i);
    end
    for (int i = 0; i < 10; i++) begin
      do_read(1'b1, 8'(i), v);
      check($sformatf("R5 R9 key %0d", i), v, kexp[i]);
    end

    // R6 table sweep with junk upper bits
    for (int i = 0; i < 256; i++)
      do_write(1'b0, 8'(i), 32'hABCD_0000 | 32'(i * 5 + 3));
    for (int i = 0; i < 256; i++) begin
      do_read(1'b0, 8'(i), v);
      check($sformatf("R6 tbl %0d", i), v, 32'((i * 5 + 3) & 15));
    end

    // R3 command write with busy clear starts nothing
    reg_write(2'd2, 32'h1234_5678);
    reg_write(2'd1, cmdw(1'b1, 1'b0, 8'd3, 1'b0));
    reg_read(2'd1, v); check("R3 cmd fields", v, 32'h0000_0304);
    reg_read(2'd2, v); check("R3 data kept", v, 32'h1234_5678);
    do_read(1'b1, 8'd3, v); check("R3 key3 kept", v, kexp[3]);

    // R4 busy window of two cycles
    reg_write(2'd2, 32'h0000_0009);
    reg_write(2'd1, cmdw(1'b0, 1'b0, 8'd40, 1'b1));
    reg_read(2'd1, v); check("R4 busy c1", v & 32'h1, 32'h1);
    reg_read(2'd1, v); check("R4 busy c2", v & 32'h1, 32'h1);
    reg_read(2'd1, v); check("R4 busy clear", v, cmdw(1'b0, 1'b0, 8'd40, 1'b0));
    do_read(1'b0, 8'd40, v); check("R4 tbl40", v, 32'h9);

    // R8 writes during busy ignored
    reg_write(2'd2, 32'hCAFE_0001);
    reg_write(2'd1, cmdw(1'b1, 1'b0, 8'd2, 1'b1));
    reg_write(2'd2, 32'hDEAD_0000);
    reg_write(2'd1, cmdw(1'b1, 1'b0, 8'd7, 1'b1));
    wait_idle("R8");
    kexp[2] = 32'hCAFE_0001;
    reg_read(2'd1, v); check("R8 cmd kept", v, cmdw(1'b1, 1'b0, 8'd2, 1'b0));
    reg_read(2'd2, v); check("R8 data kept", v, 32'hCAFE_0001);
    do_read(1'b1, 8'd2, v); check("R8 key2", v, kexp[2]);
    do_read(1'b1, 8'd7, v); check("R8 key7", v, kexp[7]);

    // R7 out-of-range key index
    do_write(1'b1, 8'd10, 32'h1111_1111);
    reg_read(2'd1, v); check("R7 cleared", v, cmdw(1'b1, 1'b0, 8'd10, 1'b0));
    do_write(1'b1, 8'd255, 32'h2222_2222);
    do_read(1'b1, 8'd10, v); check("R7 read 10", v, 32'h0);
    do_read(1'b1, 8'd15, v); check("R7 read 15", v, 32'h0);
    for (int i = 0; i < 10; i++) begin
      do_read(1'b1, 8'(i), v);
      check($sformatf("R7 key %0d intact", i), v, kexp[i]);
    end

    finish_run();
  end
endmodule